// File: doc/BRIEF.md
# Ethernet Length Field Checker

This block watches a received Ethernet frame as it arrives one byte at a time. It measures how many bytes the frame carries and compares that figure with the 16-bit length/type field in the frame header. When the block is enabled and the frame carries less payload than the field announces, the block flags the frame for discard and counts it. The neighbouring receive logic then drops the frame.

The check covers only frames that hold a real length value, not an EtherType, and only frames whose total size lies inside the legal untagged range. Frames outside these limits always pass. The payload figure is the total byte count minus the 14-byte header and the 4-byte FCS. The error counter is 10 bits wide. It holds at its top value instead of wrapping, and a synchronous clear input sets it back to zero.

Top module: `eth_lenchk`

## Requirements
- R1: When `chk_en` is low in the cycle of the last byte, the frame is not flagged and the error counter does not change.
- R2: The field is formed from frame byte 13 as bits [15:8] and frame byte 14 as bits [7:0]. Bytes are numbered from 1 at the start-of-frame byte.
- R3: A checked frame is flagged when (total byte count − 18) is strictly less than the field value. Equality passes.
- R4: A field value of 0x0600 or above is never flagged.
- R5: Only frames of 64 to 1518 bytes inclusive are checked. A frame of 63 or 1519 bytes passes.
- R6: Each flagged frame raises the 10-bit error counter by exactly one, on the same clock edge that raises `discard_o`.
- R7: The error counter saturates at 1023.
- R8: When `cnt_clr` is high at a clock edge, the counter is zero after that edge. Clear takes priority over an increment in the same cycle.
- R9: `discard_o` is a single-cycle pulse in the cycle after the byte that carries `byte_eof`. Both outputs are zero in reset.
- R10: A frame that ends before its 14th byte is never flagged.
- R11: Bytes with `byte_vld` low are ignored. Valid bytes outside a frame (no start seen since the last end) are ignored. A new start-of-frame in the middle of a frame drops the old frame and begins counting afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A byte is present on `byte_data` this cycle |
| byte_sof | input | 1 | This byte is the first of a frame |
| byte_eof | input | 1 | This byte is the last of a frame |
| byte_data | input | 8 | Frame byte |
| chk_en | input | 1 | Enables the length check |
| cnt_clr | input | 1 | Synchronous clear of the error counter |
| discard_o | output | 1 | One-cycle discard pulse after a failing frame ends |
| err_cnt_o | output | 10 | Saturating count of discarded frames |

## Verification
Faults in this block's state show up in only two places. A wrong byte count, a mis-captured field byte or a stuck in-frame flag is invisible until the end of a frame. It then shows as a missing or extra `discard_o` pulse one cycle after the final byte, together with a counter value that is off by one from that edge on. The bench uses frames sized exactly at the payload-equality edge, at both ends of the size window, and at the 0x05FF/0x0600 field boundary. It also sends byte-swapped field values, idle gaps, stray bytes and aborted frames, so that a fault moves at least one pulse. A per-cycle reference model pins each fault to the exact cycle where it appears.

// File: rtl/eth_lenchk_pkg.sv
package eth_lenchk_pkg;
  localparam int unsigned LEN_W = 16;
  typedef logic [LEN_W-1:0] len_t;

  typedef struct packed {
    logic done;   // the frame ends on this cycle's byte
    len_t size;   // total bytes including this one
    len_t field;  // length/type field as captured so far
  } frame_sum_t;
endpackage

// File: rtl/lenchk_bytecnt.sv
module lenchk_bytecnt
  import eth_lenchk_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic       byte_sof,
  input  logic       byte_eof,
  input  logic [7:0] byte_data,
  output frame_sum_t summ
);
  localparam len_t POS_HI  = len_t'(HDR_BYTES - 1);
  localparam len_t POS_LO  = len_t'(HDR_BYTES);
  localparam len_t CNT_TOP = '1;

  logic cnt_en;
  logic in_q, in_n;
  len_t cnt_q, cnt_n;
  len_t fld_q, fld_n;

  assign cnt_en = byte_vld & (byte_sof | in_q);

  always_comb begin
    cnt_n = cnt_q;
    fld_n = fld_q;
    in_n  = in_q;
    if (cnt_en) begin
      if (byte_sof) begin
        cnt_n = len_t'(1);
        fld_n = '0;
      end else if (cnt_q != CNT_TOP) begin
        cnt_n = cnt_q + len_t'(1);
      end
      if (cnt_n == POS_HI) fld_n[15:8] = byte_data;
      if (cnt_n == POS_LO) fld_n[7:0]  = byte_data;
      in_n = ~byte_eof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fld_q <= '0;
      in_q  <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
      fld_q <= fld_n;
      in_q  <= in_n;
    end
  end

  assign summ.done  = cnt_en & byte_eof;
  assign summ.size  = cnt_n;
  assign summ.field = fld_n;
endmodule

// File: rtl/lenchk_judge.sv
module lenchk_judge
  import eth_lenchk_pkg::*;
#(
  parameter int unsigned MIN_BYTES  = 64,
  parameter int unsigned MAX_BYTES  = 1518,
  parameter int unsigned HDR_BYTES  = 14,
  parameter int unsigned OVH_BYTES  = 18,
  parameter int unsigned TYPE_FLOOR = 16'h0600
) (
  input  frame_sum_t summ,
  input  logic       chk_en,
  output logic       hit
);
  localparam len_t MIN_L  = len_t'(MIN_BYTES);
  localparam len_t MAX_L  = len_t'(MAX_BYTES);
  localparam len_t HDR_L  = len_t'(HDR_BYTES);
  localparam len_t OVH_L  = len_t'(OVH_BYTES);
  localparam len_t TYPE_L = len_t'(TYPE_FLOOR);

  logic in_win, is_len, hdr_ok, short_pl;
  len_t payload;

  always_comb begin
    in_win   = (summ.size >= MIN_L) && (summ.size <= MAX_L);
    is_len   = summ.field < TYPE_L;
    hdr_ok   = summ.size >= HDR_L;
    payload  = summ.size - OVH_L;
    short_pl = (summ.size >= OVH_L) && (payload < summ.field);
    hit      = summ.done & chk_en & in_win & is_len & hdr_ok & short_pl;
  end
endmodule

// File: rtl/lenchk_errcnt.sv
module lenchk_errcnt #(
  parameter int unsigned ERR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [ERR_W-1:0] cnt
);
  localparam logic [ERR_W-1:0] CNT_TOP = '1;

  logic [ERR_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  assign cnt_en = clr | (inc & (cnt_q != CNT_TOP));

  always_comb begin
    if (clr) cnt_n = '0;
    else     cnt_n = cnt_q + {{(ERR_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/eth_lenchk.sv
module eth_lenchk
  import eth_lenchk_pkg::*;
#(
  parameter int unsigned MIN_BYTES  = 64,
  parameter int unsigned MAX_BYTES  = 1518,
  parameter int unsigned HDR_BYTES  = 14,
  parameter int unsigned OVH_BYTES  = 18,
  parameter int unsigned TYPE_FLOOR = 16'h0600,
  parameter int unsigned ERR_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             byte_sof,
  input  logic             byte_eof,
  input  logic [7:0]       byte_data,
  input  logic             chk_en,
  input  logic             cnt_clr,
  output logic             discard_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  frame_sum_t summ;
  logic       hit;
  logic       drop_q;

  lenchk_bytecnt #(.HDR_BYTES(HDR_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_sof(byte_sof),
    .byte_eof(byte_eof), .byte_data(byte_data), .summ(summ)
  );

  lenchk_judge #(
    .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES), .HDR_BYTES(HDR_BYTES),
    .OVH_BYTES(OVH_BYTES), .TYPE_FLOOR(TYPE_FLOOR)
  ) u_judge (
    .summ(summ), .chk_en(chk_en), .hit(hit)
  );

  lenchk_errcnt #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(hit), .cnt(err_cnt_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= hit;
  end

  assign discard_o = drop_q;
endmodule

// File: rtl/eth_lenchk_chk.sv
module eth_lenchk_chk #(
  parameter int unsigned ERR_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             byte_eof,
  input logic             chk_en,
  input logic             cnt_clr,
  input logic             discard_o,
  input logic [ERR_W-1:0] err_cnt_o
);
  localparam logic [ERR_W-1:0] TOP = '1;

  AST_OFF_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !discard_o);  // R1
  AST_DROP_ONLY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && byte_eof) |=> !discard_o);  // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    discard_o |=> !discard_o);  // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && err_cnt_o != TOP) |=>
      err_cnt_o == $past(err_cnt_o) + {{(ERR_W-1){1'b0}}, discard_o});  // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && err_cnt_o == TOP) |=> err_cnt_o == TOP);  // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> err_cnt_o == '0);  // R8
endmodule

bind eth_lenchk eth_lenchk_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_eof(byte_eof),
  .chk_en(chk_en), .cnt_clr(cnt_clr), .discard_o(discard_o), .err_cnt_o(err_cnt_o)
);

// File: tb/eth_lenchk_test.sv
`timescale 1ns/1ps
module eth_lenchk_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0, byte_sof = 1'b0, byte_eof = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       chk_en = 1'b0, cnt_clr = 1'b0;
  logic       discard_o;
  logic [9:0] err_cnt_o;

  int    checks = 0, fails = 0;
  string cur_req = "R9";
  bit    saw_drop = 0;
  int    want = 0;
  bit    done = 0;

  // behavioural reference model
  int m_cnt = 0, m_fld = 0, exp_drop = 0, exp_cnt = 0;
  bit m_in = 0;

  always #2 clk = ~clk;

  eth_lenchk uut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_sof(byte_sof),
    .byte_eof(byte_eof), .byte_data(byte_data), .chk_en(chk_en),
    .cnt_clr(cnt_clr), .discard_o(discard_o), .err_cnt_o(err_cnt_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_fld = 0; m_in = 0; exp_drop = 0; exp_cnt = 0;
    end else begin
      int hit;
      hit = 0;
      if (byte_vld && (byte_sof || m_in)) begin
        if (byte_sof) begin m_cnt = 1; m_fld = 0; end
        else m_cnt = m_cnt + 1;
        if (m_cnt == 13) m_fld = (m_fld & 'hff) | (int'(byte_data) << 8);
        if (m_cnt == 14) m_fld = (m_fld & 'hff00) | int'(byte_data);
        if (byte_eof) begin
          m_in = 0;
          if (chk_en && m_cnt >= 64 && m_cnt <= 1518 && m_fld < 'h600 && (m_cnt - 18) < m_fld)
            hit = 1;
        end else m_in = 1;
      end
      exp_drop = hit;
      if (cnt_clr) exp_cnt = 0;
      else if (hit != 0 && exp_cnt < 1023) exp_cnt = exp_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (discard_o) saw_drop = 1;
    checks++;
    if (discard_o !== exp_drop[0] || err_cnt_o !== exp_cnt[9:0]) begin
      fails++;
      $display("FAIL %s cycle model: discard=%0b cnt=%0d expected discard=%0d cnt=%0d",
               cur_req, discard_o, err_cnt_o, exp_drop, exp_cnt);
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(string req, int len, int field, bit en, bit gaps,
                            bit exp_hit, bit clr_end);
    cur_req = req;
    @(negedge clk);
    chk_en = en; saw_drop = 0;
    for (int i = 1; i <= len; i++) begin
      if (i > 1) @(negedge clk);
      byte_vld = 1; byte_sof = (i == 1); byte_eof = (i == len);
      byte_data = (i == 13) ? 8'(field >> 8) : (i == 14) ? 8'(field) : 8'(i * 7);
      cnt_clr = clr_end && (i == len);
      if (gaps && (i % 5 == 0) && i != len) begin
        @(negedge clk);
        byte_vld = 0; byte_sof = 0; byte_eof = 0;
      end
    end
    @(negedge clk);
    byte_vld = 0; byte_sof = 0; byte_eof = 0; cnt_clr = 0;
    repeat (2) @(negedge clk);
    check({req, " discard"}, int'(saw_drop), int'(exp_hit));
    if (clr_end) want = 0;
    else if (exp_hit && want < 1023) want++;
    check({req, " counter"}, int'(err_cnt_o), want);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset discard", int'(discard_o), 0);
    check("R9 reset counter", int'(err_cnt_o), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R3 equality edge and one above
    send_frame("R3", 64, 46, 1, 0, 0, 0);
    send_frame("R3", 64, 47, 1, 0, 1, 0);
    send_frame("R3", 200, 182, 1, 1, 0, 0);
    send_frame("R3", 200, 183, 1, 1, 1, 0);
    // R5 window
    send_frame("R5", 1518, 1500, 1, 0, 0, 0);
    send_frame("R5", 1518, 1501, 1, 0, 1, 0);
    send_frame("R5", 1519, 1535, 1, 0, 0, 0);
    send_frame("R5", 63, 1000, 1, 0, 0, 0);
    // R4 type boundary
    send_frame("R4", 64, 'h05FF, 1, 0, 1, 0);
    send_frame("R4", 64, 'h0600, 1, 0, 0, 0);
    send_frame("R4", 64, 'hFFFF, 1, 0, 0, 0);
    // R2 byte order: 0x0005 passes, swapped 0x0500 fails
    send_frame("R2", 100, 'h0005, 1, 0, 0, 0);
    send_frame("R2", 100, 'h0500, 1, 0, 1, 0);
    // R1 disabled
    send_frame("R1", 64, 1000, 0, 0, 0, 0);
    // R10 short frames
    send_frame("R10", 10, 0, 1, 0, 0, 0);
    send_frame("R10", 13, 'h0500, 1, 0, 0, 0);
    // R11 stray bytes outside frame, then aborted frame restarted by a new start
    cur_req = "R11";
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); byte_vld = 1; byte_sof = 0; byte_eof = (i == 79); byte_data = 8'h01;
    end
    @(negedge clk); byte_vld = 0; byte_eof = 0;
    repeat (2) @(negedge clk);
    check("R11 stray bytes counter", int'(err_cnt_o), want);
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk); byte_vld = 1; byte_sof = (i == 1); byte_eof = 0; byte_data = 8'h06;
    end
    send_frame("R11", 64, 47, 1, 1, 1, 0);
    // R8 clear beats increment
    send_frame("R8", 64, 100, 1, 0, 1, 1);
    // R6 / R7 saturation
    for (int k = 0; k < 1030; k++) send_frame("R7", 64, 100, 1, 0, 1, 0);
    check("R7 saturated", int'(err_cnt_o), 1023);
    send_frame("R6", 64, 46, 1, 0, 0, 0);
    cur_req = "R8";
    @(negedge clk); cnt_clr = 1;
    @(negedge clk); cnt_clr = 0;
    check("R8 clear", int'(err_cnt_o), 0);
    want = 0;
    send_frame("R6", 64, 47, 1, 0, 1, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule